// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

This block is a private countdown timer for a single processor core. Software reaches it through a small word-wide register window. It can program a start value, read or overwrite the live count, and select run, auto-reload and a clock divider. It also reads and acknowledges an expiry flag. The count falls by one after every (P+1) cycles of the input clock while the timer runs. When the count arrives at zero, a sticky flag is raised, and the interrupt line follows that flag as a level.

In one-shot use the timer parks at zero after expiring. In periodic use it refills from the stored start value and keeps going. The period is then the start value times (P+1) clock cycles. Reads have no side effects and return combinationally in the same cycle as the address. Writes take effect at the next rising clock edge.

Top module: `pdt_timer`

## Requirements
- R1: After reset, the load, count, control and status values are all zero, the divider phase is zero and `irq` is low.
- R2: Registers are selected by byte offset: 0x0 start value, 0x4 live count, 0x8 control, 0xC status. Every other offset reads as zero, and a write to it changes no register.
- R3: Control bit 0 is run, control bit 1 is auto-reload, and control bits 15:8 are the divider value P. A control read returns those bits, with every other bit zero.
- R4: While running, the count drops by one every (P+1) clock cycles. The divider phase restarts on any start-value or count write and when run goes from 0 to 1, so the first decrement comes a full (P+1) cycles later.
- R5: A start-value write sets both the stored start value and the live count. A count write changes only the live count.
- R6: When a decrement would take the count from 1 to 0, the status flag is set. In one-shot mode the count then stays at zero.
- R7: In auto-reload mode an expiry loads the count from the stored start value, so expiries repeat every start value × (P+1) cycles.
- R8: A control write that turns run on while the count is zero and auto-reload is being set first copies the stored start value into the count.
- R9: A zero count, even while running, never decrements and never raises a new expiry.
- R10: A count read returns zero while run is clear or the count is zero. Otherwise it returns the live count.
- R11: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. `irq` equals the flag. An expiry in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
A wrong divider phase shows up as a count read that changes one or more cycles early or late after an enable or a count write. The first decrement after such an event exposes it within P+1 cycles. A wrong count or a bad reload shows at the count port on the next tick, and at `irq` at the expiry edge, which moves by a whole divider period for each unit of error. A status flag with the wrong priority or stickiness shows on `irq` in the cycle right after the clear write that collides with an expiry.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  parameter int unsigned PDT_DW     = 32;
  parameter int unsigned PRESC_W    = 8;
  parameter int unsigned PRESC_LSB  = 8;
  parameter int unsigned EN_BIT     = 0;
  parameter int unsigned RELOAD_BIT = 1;
  parameter int unsigned STAT_BIT   = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD,
    SEL_COUNT,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;

  // Byte-offset decode; offsets are fixed by the software view.
  function automatic reg_sel_e pdt_decode(input logic [7:0] a);
    case (a)
      8'h00:   return SEL_LOAD;
      8'h04:   return SEL_COUNT;
      8'h08:   return SEL_CTRL;
      8'h0C:   return SEL_STAT;
      default: return SEL_NONE;
    endcase
  endfunction

  // Control register as software sees it.
  function automatic logic [PDT_DW-1:0] pdt_ctrl_view(input logic en,
                                                      input logic reload,
                                                      input logic [PRESC_W-1:0] p);
    logic [PDT_DW-1:0] v;
    v = '0;
    v[EN_BIT] = en;
    v[RELOAD_BIT] = reload;
    v[PRESC_LSB +: PRESC_W] = p;
    return v;
  endfunction

  // Count as software sees it: hidden while stopped.
  function automatic logic [PDT_DW-1:0] pdt_count_view(input logic en,
                                                       input logic [PDT_DW-1:0] c);
    return en ? c : '0;
  endfunction

  // True when the next tick ends the current run.
  function automatic logic pdt_is_last(input logic [PDT_DW-1:0] c);
    return c == PDT_DW'(1);
  endfunction

endpackage

// File: rtl/pdt_prescale.sv
module pdt_prescale #(
  parameter int unsigned PW = pdt_pkg::PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  input  logic [PW-1:0] presc,
  output logic          tick
);

  logic [PW-1:0] ph;

  // A shrinking divider value never strands the phase above it.
  assign tick = en && !restart && (ph >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ph <= '0;
    else if (!en || restart || tick) ph <= '0;
    else                           ph <= ph + PW'(1);
  end

  // R4: with a nonzero divider, ticks never come back to back
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0) |=> (!tick || presc == '0));

  // R4: a restart leaves the phase at its origin
  assert_restart_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ph == '0));

endmodule

// File: rtl/pdt_count.sv
module pdt_count #(
  parameter int unsigned DW = pdt_pkg::PDT_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wdata,
  input  logic          arm_load,
  input  logic          reload,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt,
  output logic          expire
);
  import pdt_pkg::*;

  logic cnt_zero;
  assign cnt_zero = (cnt == '0);
  assign expire   = tick && !cnt_wr && pdt_is_last(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (arm_load && cnt_zero) begin
      cnt <= load_val;
    end else if (tick && !cnt_zero) begin
      if (expire) cnt <= reload ? load_val : '0;
      else        cnt <= cnt - DW'(1);
    end
  end

  // R4: an ordinary tick removes exactly one
  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !arm_load && cnt > DW'(1)) |=> (cnt == $past(cnt) - DW'(1)));

  // R6: one-shot expiry parks at zero
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload) |=> (cnt == '0));

  // R7: periodic expiry refills from the start value
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload) |=> (cnt == $past(load_val)));

  // R9: a zero count stays put and never expires
  assert_zero_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !cnt_wr && !arm_load) |=> (cnt == '0));
  assert_zero_no_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |-> !expire);

endmodule

// File: rtl/pdt_regs.sv
module pdt_regs #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DW     = pdt_pkg::PDT_DW,
  parameter int unsigned PW     = pdt_pkg::PRESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              expire,
  input  logic [DW-1:0]     cnt,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     load_q,
  output logic              en_q,
  output logic              reload_q,
  output logic [PW-1:0]     presc_q,
  output logic              status_q,
  output logic              cnt_wr,
  output logic              arm_load,
  output logic              restart
);
  import pdt_pkg::*;

  reg_sel_e sel;
  logic wr_load, wr_cnt, wr_ctrl, wr_stat, en_rise, stat_clr;

  assign sel      = pdt_decode(8'(addr));
  assign wr_load  = wr && (sel == SEL_LOAD);
  assign wr_cnt   = wr && (sel == SEL_COUNT);
  assign wr_ctrl  = wr && (sel == SEL_CTRL);
  assign wr_stat  = wr && (sel == SEL_STAT);
  assign stat_clr = wr_stat && wdata[STAT_BIT];
  assign en_rise  = wr_ctrl && wdata[EN_BIT] && !en_q;
  assign arm_load = en_rise && wdata[RELOAD_BIT];
  assign cnt_wr   = wr_load || wr_cnt;
  assign restart  = cnt_wr || en_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '0;
      en_q     <= 1'b0;
      reload_q <= 1'b0;
      presc_q  <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        en_q     <= wdata[EN_BIT];
        reload_q <= wdata[RELOAD_BIT];
        presc_q  <= wdata[PRESC_LSB +: PW];
      end
      if (expire)        status_q <= 1'b1;
      else if (stat_clr) status_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_LOAD:  rdata = load_q;
      SEL_COUNT: rdata = pdt_count_view(en_q, cnt);
      SEL_CTRL:  rdata = pdt_ctrl_view(en_q, reload_q, presc_q);
      SEL_STAT:  rdata[STAT_BIT] = status_q;
      default:   rdata = '0;
    endcase
  end

  // R6: an expiry always leaves the flag raised
  assert_expire_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status_q);

  // R11: the flag is sticky until a one is written to it
  assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !stat_clr) |=> status_q);

  // R11: a clear without a colliding expiry drops the flag
  assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !expire) |=> !status_q);

  // R2: writes to unmapped offsets change nothing
  assert_unmapped_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=> ($stable(load_q) && $stable(en_q) &&
                                 $stable(reload_q) && $stable(presc_q)));

endmodule

// File: rtl/pdt_timer.sv
module pdt_timer #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  import pdt_pkg::*;

  localparam int unsigned DW = PDT_DW;
  localparam int unsigned PW = PRESC_W;

  logic [DW-1:0] load_q, cnt;
  logic [PW-1:0] presc_q;
  logic en_q, reload_q, status_q, cnt_wr, arm_load, restart, tick, expire;

  pdt_regs #(.ADDR_W(ADDR_W), .DW(DW), .PW(PW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .expire   (expire),
    .cnt      (cnt),
    .rdata    (reg_rdata),
    .load_q   (load_q),
    .en_q     (en_q),
    .reload_q (reload_q),
    .presc_q  (presc_q),
    .status_q (status_q),
    .cnt_wr   (cnt_wr),
    .arm_load (arm_load),
    .restart  (restart)
  );

  pdt_prescale #(.PW(PW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .restart (restart),
    .presc   (presc_q),
    .tick    (tick)
  );

  pdt_count #(.DW(DW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (reg_wdata),
    .arm_load  (arm_load),
    .reload    (reload_q),
    .load_val  (load_q),
    .cnt       (cnt),
    .expire    (expire)
  );

  assign irq = status_q;

  // R8: enabling an empty periodic timer pulls in the start value
  assert_arm_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_load && !cnt_wr && cnt == '0) |=> (cnt == $past(load_q)));

endmodule

// File: tb/tb_pdt_timer.sv
`timescale 1ns/1ps
module tb_pdt_timer;

  localparam int unsigned AW = 5;
  localparam logic [AW-1:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                            A_STAT = 5'h0C, A_HOLE0 = 5'h10, A_HOLE1 = 5'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pdt_timer #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; the write lands on the next rising edge.
  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_STAT, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(A_LOAD, v); chk("R1 load after reset", v, 0);
    rd_reg(A_CNT, v);  chk("R1 count after reset", v, 0);
    rd_reg(A_CTRL, v); chk("R1 ctrl after reset", v, 0);
    rd_reg(A_STAT, v); chk("R1 status after reset", v, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl_and_holes();
    logic [31:0] v;
    wr_reg(A_CTRL, 32'hFFFF_FFFC);
    rd_reg(A_CTRL, v); chk("R3 ctrl readback masks", v, 32'h0000_FF00);
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_LOAD, 32'h0000_0055);
    wr_reg(A_HOLE1, 32'hDEAD_BEEF);
    rd_reg(A_HOLE0, v); chk("R2 unmapped read 0x10", v, 0);
    rd_reg(A_HOLE1, v); chk("R2 unmapped read 0x14", v, 0);
    rd_reg(A_LOAD, v);  chk("R2 load untouched by hole write", v, 32'h55);
    rd_reg(A_CTRL, v);  chk("R2 ctrl untouched by hole write", v, 0);
  endtask

  task automatic t_oneshot_prescale();
    logic [31:0] v;
    wr_reg(A_LOAD, 32'd5);
    rd_reg(A_CNT, v); chk("R10 count hidden while stopped", v, 0);
    wr_reg(A_CTRL, 32'h0000_0301);           // P=3, run, one-shot
    rd_reg(A_CNT, v); chk("R5 load write set count", v, 5);
    idle(3); rd_reg(A_CNT, v); chk("R4 no decrement before P+1", v, 5);
    idle(1); rd_reg(A_CNT, v); chk("R4 first decrement at P+1", v, 4);
    idle(15); rd_reg(A_CNT, v); chk("R4 count one before expiry", v, 1);
    chk("R6 irq low before expiry", {31'b0, irq}, 0);
    idle(1); rd_reg(A_CNT, v); chk("R6 count zero at expiry", v, 0);
    chk("R6 irq high at expiry", {31'b0, irq}, 1);
    idle(9); rd_reg(A_CNT, v); chk("R6 one-shot stays stopped", v, 0);
    rd_reg(A_STAT, v); chk("R11 status sticky", v, 1);
    wr_reg(A_STAT, 32'h0);
    rd_reg(A_STAT, v); chk("R11 writing zero keeps flag", v, 1);
    wr_reg(A_STAT, 32'h1);
    rd_reg(A_STAT, v); chk("R11 writing one clears flag", v, 0);
    chk("R11 irq follows flag", {31'b0, irq}, 0);
  endtask

  task automatic t_reload_collision();
    logic [31:0] v;
    quiesce();
    wr_reg(A_LOAD, 32'd3);
    wr_reg(A_CTRL, 32'h0000_0003);           // P=0, run, reload
    for (int k = 0; k < 9; k++) begin
      rd_reg(A_CNT, v);
      chk($sformatf("R7 periodic count k=%0d", k), v, 32'(3 - (k % 3)));
      idle(1);
    end
    chk("R7 irq after periodic expiry", {31'b0, irq}, 1);
    idle(1);
    wr_reg(A_STAT, 32'h1);                   // lands with the expiry edge
    rd_reg(A_STAT, v); chk("R11 expiry beats clear", v, 1);
    wr_reg(A_STAT, 32'h1);
    rd_reg(A_STAT, v); chk("R11 clear between expiries", v, 0);
  endtask

  task automatic t_zero_and_arm();
    logic [31:0] v;
    quiesce();
    wr_reg(A_LOAD, 32'd4);
    wr_reg(A_CNT, 32'd0);
    rd_reg(A_LOAD, v); chk("R5 count write leaves load", v, 4);
    wr_reg(A_CTRL, 32'h0000_0001);           // run, one-shot, count zero
    rd_reg(A_CNT, v); chk("R10 zero count reads zero", v, 0);
    idle(10);
    chk("R9 zero count raises no expiry", {31'b0, irq}, 0);
    rd_reg(A_CNT, v); chk("R9 zero count does not move", v, 0);
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_CTRL, 32'h0000_0003);           // run rising with reload
    rd_reg(A_CNT, v); chk("R8 enable pulls start value", v, 4);
  endtask

  task automatic t_count_write_restart();
    logic [31:0] v;
    quiesce();
    wr_reg(A_LOAD, 32'd10);
    wr_reg(A_CTRL, 32'h0000_0301);           // P=3, run, one-shot
    wr_reg(A_CNT, 32'd7);                    // mid-phase rewrite
    rd_reg(A_LOAD, v); chk("R5 count write keeps load", v, 10);
    rd_reg(A_CNT, v); chk("R5 count write value", v, 7);
    idle(3); rd_reg(A_CNT, v); chk("R4 phase restarted by count write", v, 7);
    idle(1); rd_reg(A_CNT, v); chk("R4 decrement after restart", v, 6);
    wr_reg(A_LOAD, 32'd20);
    rd_reg(A_CNT, v); chk("R5 load write while running", v, 20);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_ctrl_and_holes();
    t_oneshot_prescale();
    t_reload_collision();
    t_zero_and_arm();
    t_count_write_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule